// File: doc/BRIEF.md
# Dual-Rate Cascaded PI Converter Controller

This block closes the control loops of a current-fed DC-DC converter in fixed point. An outer voltage loop compares the sampled output voltage with a setpoint and produces a reference for the converter's input current. An inner current loop compares the sampled input current with that reference and produces a duty-cycle word for a PWM stage. Both loops are proportional-integral stages with output clamping and conditional-integration anti-windup. All values are signed 32-bit Q16.16 words: 16 integer bits and 16 fraction bits, two's complement.

A single sample stream drives both loops. Every accepted sample updates the current loop. The voltage loop updates on every eighth accepted sample, so a 20 kHz current loop gives a 2.5 kHz voltage loop. The sample input is a valid/ready stream whose ready is tied high. The block never applies back-pressure, and a sample is taken on every cycle in which `smp_valid` is high. The duty output is a valid-only stream with no ready: the PWM stage must capture `duty` on the cycle `duty_valid` pulses, and the word then holds until the next accepted sample. Gains, setpoint and limits are plain static inputs. Integral gains are given as per-sample increments, Ki times the sample period.

Top module: `cascade_pi_ctrl`

## Requirements
- R1: `smp_ready` is always 1. When `smp_valid` is high at a clock edge, `duty` shows the new value after that edge and `duty_valid` is high for exactly that one cycle. With no sample, `duty_valid` is 0.
- R2: A 3-bit counter counts accepted samples, starting from 0 after reset. The voltage loop updates only on the sample where the counter wraps from 7 to 0, which is the 8th, 16th and so on after reset. `iref` changes only after such a sample. The current loop update on that same sample already uses the new reference.
- R3: Each loop computes e = ref − meas. P = (kp·e) >>> 16. The candidate integrator is the old integrator plus (ki·e) >>> 16. The unclamped output is P plus the candidate. Every product is the full signed product, shifted right arithmetically by 16.
- R4: `iref` is clamped to the range [0, `iref_max`]. A negative `iref_max` is treated as 0.
- R5: `duty` is clamped to the range [0, min(`duty_max`, 0x0000FFFF)], which keeps it strictly below 1.0. A negative `duty_max` is treated as 0.
- R6: If a loop's unclamped output lies outside its clamp range, that loop's integrator keeps its previous value. Otherwise the integrator takes the candidate value.
- R7: Every subtraction, product and sum saturates to the range [−2^31, 2^31−1] instead of wrapping.
- R8: A synchronous high `rst` clears both integrators and the counter, and drives `duty`, `iref` and `duty_valid` to 0 after the next edge.
- R9: A cycle with `smp_valid` low leaves `duty`, `iref`, both integrators and the counter unchanged, whatever the values on the sample inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| smp_valid | input | 1 | Sample word pair valid |
| smp_ready | output | 1 | Always 1; no back-pressure |
| v_meas | input | 32 | Sampled output voltage, Q16.16 |
| i_meas | input | 32 | Sampled input current, Q16.16 |
| v_set | input | 32 | Voltage setpoint, Q16.16 |
| kp_v | input | 32 | Voltage loop proportional gain, Q16.16 |
| ki_v | input | 32 | Voltage loop integral increment per sample, Q16.16 |
| kp_i | input | 32 | Current loop proportional gain, Q16.16 |
| ki_i | input | 32 | Current loop integral increment per sample, Q16.16 |
| iref_max | input | 32 | Upper limit of the current reference, Q16.16 |
| duty_max | input | 32 | Upper limit of the duty word, Q16.16 |
| duty | output | 32 | Saturated duty command, Q16.16 |
| duty_valid | output | 1 | One-cycle pulse when `duty` is updated |
| iref | output | 32 | Present current reference from the voltage loop, Q16.16 |

## Verification
A corrupted current-loop integrator shows up in `duty` on the very next accepted sample. A corrupted voltage-loop integrator stays hidden until the next wrap of the counter, which can be up to eight samples later, and then appears in `iref` and in `duty` on that same cycle. A counter that is off by one moves every `iref` change to the wrong sample. Broken anti-windup shows only once a loop has been driven into its clamp and then released, as a slow recovery of `duty`. The bench therefore runs a reference model against every cycle, uses both dense and sparse sample patterns, and includes saturating stretches followed by recovery.

// File: rtl/ccpi_pkg.sv
package ccpi_pkg;
  localparam int QW   = 32;
  localparam int FRAC = 16;
  localparam int XW   = 2 * QW;

  typedef logic signed [QW-1:0] q_t;
  typedef logic signed [XW-1:0] x_t;

  localparam q_t Q_MAX = {1'b0, {(QW-1){1'b1}}};
  localparam q_t Q_MIN = {1'b1, {(QW-1){1'b0}}};
  localparam q_t DUTY_CEIL = q_t'((64'd1 << FRAC) - 64'd1);

  function automatic x_t widen(input q_t a);
    return {{QW{a[QW-1]}}, a};
  endfunction

  function automatic q_t sat(input x_t x);
    if (x > widen(Q_MAX)) return Q_MAX;
    if (x < widen(Q_MIN)) return Q_MIN;
    return x[QW-1:0];
  endfunction

  function automatic q_t qadd(input q_t a, input q_t b);
    return sat(widen(a) + widen(b));
  endfunction

  function automatic q_t qsub(input q_t a, input q_t b);
    return sat(widen(a) - widen(b));
  endfunction

  function automatic q_t qmul(input q_t a, input q_t b);
    x_t p;
    p = widen(a) * widen(b);
    return sat(p >>> FRAC);
  endfunction
endpackage

// File: rtl/ccpi_rate_div.sv
module ccpi_rate_div #(
  parameter int RATIO_LOG2 = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  output logic wrap
);
  localparam logic [RATIO_LOG2-1:0] LAST = '1;

  logic [RATIO_LOG2-1:0] cnt;

  assign wrap = tick && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst)       cnt <= '0;
    else if (tick) cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/ccpi_pi_stage.sv
module ccpi_pi_stage
  import ccpi_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  q_t   ref_in,
  input  q_t   meas,
  input  q_t   kp,
  input  q_t   ki,
  input  q_t   lo,
  input  q_t   hi,
  output q_t   u,
  output logic clamped,
  output q_t   integ
);
  q_t err, prop, cand, total;

  always_comb begin
    err     = qsub(ref_in, meas);
    prop    = qmul(kp, err);
    cand    = qadd(integ, qmul(ki, err));
    total   = qadd(prop, cand);
    clamped = (total > hi) || (total < lo);
    if (total > hi)      u = hi;
    else if (total < lo) u = lo;
    else                 u = total;
  end

  always_ff @(posedge clk) begin
    if (rst)                integ <= '0;
    else if (en && !clamped) integ <= cand;
  end
endmodule

// File: rtl/cascade_pi_ctrl.sv
module cascade_pi_ctrl
  import ccpi_pkg::*;
#(
  parameter int RATIO_LOG2 = 3
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        smp_valid,
  output logic        smp_ready,
  input  logic [31:0] v_meas,
  input  logic [31:0] i_meas,
  input  logic [31:0] v_set,
  input  logic [31:0] kp_v,
  input  logic [31:0] ki_v,
  input  logic [31:0] kp_i,
  input  logic [31:0] ki_i,
  input  logic [31:0] iref_max,
  input  logic [31:0] duty_max,
  output logic [31:0] duty,
  output logic        duty_valid,
  output logic [31:0] iref
);
  q_t   iref_q, duty_q;
  logic dv_q;
  logic v_tick;
  q_t   v_hi, d_hi, v_u, c_u, c_ref;
  logic v_clamp, c_clamp;
  q_t   v_integ, c_integ;

  assign smp_ready = 1'b1;

  always_comb begin
    if (q_t'(iref_max) < 0) v_hi = '0;
    else                    v_hi = q_t'(iref_max);
    if (q_t'(duty_max) < 0)              d_hi = '0;
    else if (q_t'(duty_max) > DUTY_CEIL) d_hi = DUTY_CEIL;
    else                                 d_hi = q_t'(duty_max);
  end

  ccpi_rate_div #(.RATIO_LOG2(RATIO_LOG2)) u_div (
    .clk  (clk),
    .rst  (rst),
    .tick (smp_valid),
    .wrap (v_tick)
  );

  ccpi_pi_stage u_volt (
    .clk     (clk),
    .rst     (rst),
    .en      (v_tick),
    .ref_in  (q_t'(v_set)),
    .meas    (q_t'(v_meas)),
    .kp      (q_t'(kp_v)),
    .ki      (q_t'(ki_v)),
    .lo      ('0),
    .hi      (v_hi),
    .u       (v_u),
    .clamped (v_clamp),
    .integ   (v_integ)
  );

  assign c_ref = v_tick ? v_u : iref_q;

  ccpi_pi_stage u_cur (
    .clk     (clk),
    .rst     (rst),
    .en      (smp_valid),
    .ref_in  (c_ref),
    .meas    (q_t'(i_meas)),
    .kp      (q_t'(kp_i)),
    .ki      (q_t'(ki_i)),
    .lo      ('0),
    .hi      (d_hi),
    .u       (c_u),
    .clamped (c_clamp),
    .integ   (c_integ)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      iref_q <= '0;
      duty_q <= '0;
      dv_q   <= 1'b0;
    end else begin
      dv_q <= smp_valid;
      if (v_tick)    iref_q <= v_u;
      if (smp_valid) duty_q <= c_u;
    end
  end

  assign duty       = duty_q;
  assign duty_valid = dv_q;
  assign iref       = iref_q;
endmodule

// File: rtl/ccpi_chk.sv
module ccpi_chk
  import ccpi_pkg::*;
(
  input logic        clk,
  input logic        rst,
  input logic        smp_valid,
  input logic        smp_ready,
  input logic [31:0] duty,
  input logic        duty_valid,
  input logic [31:0] iref,
  input logic        v_tick,
  input logic        v_clamp,
  input logic        c_clamp,
  input q_t          v_integ,
  input q_t          c_integ
);
  assert_ready_R1: assert property (@(posedge clk) disable iff (rst)
    smp_ready);

  assert_valid_follows_R1: assert property (@(posedge clk) disable iff (rst)
    duty_valid |-> $past(smp_valid));

  assert_iref_only_on_wrap_R2: assert property (@(posedge clk) disable iff (rst)
    !$stable(iref) |-> $past(v_tick));

  assert_iref_floor_R4: assert property (@(posedge clk) disable iff (rst)
    !iref[31]);

  assert_duty_window_R5: assert property (@(posedge clk) disable iff (rst)
    (!duty[31] && (q_t'(duty) <= DUTY_CEIL)));

  assert_cur_antiwindup_R6: assert property (@(posedge clk) disable iff (rst)
    (smp_valid && c_clamp) |=> $stable(c_integ));

  assert_volt_antiwindup_R6: assert property (@(posedge clk) disable iff (rst)
    (v_tick && v_clamp) |=> $stable(v_integ));

  assert_reset_clears_R8: assert property (@(posedge clk)
    rst |=> (duty == '0 && iref == '0 && !duty_valid && v_integ == '0 && c_integ == '0));

  assert_idle_holds_R9: assert property (@(posedge clk) disable iff (rst)
    !smp_valid |=> ($stable(duty) && $stable(c_integ) && $stable(v_integ)));
endmodule

bind cascade_pi_ctrl ccpi_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .smp_valid  (smp_valid),
  .smp_ready  (smp_ready),
  .duty       (duty),
  .duty_valid (duty_valid),
  .iref       (iref),
  .v_tick     (v_tick),
  .v_clamp    (v_clamp),
  .c_clamp    (c_clamp),
  .v_integ    (v_integ),
  .c_integ    (c_integ)
);

// File: tb/tb_cascade_pi_ctrl.sv
module tb_cascade_pi_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam longint QMAX = 64'sd2147483647;
  localparam longint QMIN = -64'sd2147483648;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        smp_valid = 1'b0;
  logic        smp_ready;
  logic [31:0] v_meas = '0, i_meas = '0, v_set = '0;
  logic [31:0] kp_v = '0, ki_v = '0, kp_i = '0, ki_i = '0;
  logic [31:0] iref_max = '0, duty_max = '0;
  logic [31:0] duty, iref;
  logic        duty_valid;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  string tag = "R8";

  // reference model state
  longint m_iv = 0, m_ii = 0, m_iref = 0, m_duty = 0;
  int     m_cnt = 0;
  bit     m_dv = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cascade_pi_ctrl dut (
    .clk(clk), .rst(rst), .smp_valid(smp_valid), .smp_ready(smp_ready),
    .v_meas(v_meas), .i_meas(i_meas), .v_set(v_set),
    .kp_v(kp_v), .ki_v(ki_v), .kp_i(kp_i), .ki_i(ki_i),
    .iref_max(iref_max), .duty_max(duty_max),
    .duty(duty), .duty_valid(duty_valid), .iref(iref)
  );

  function automatic longint s32(input logic [31:0] x);
    return longint'($signed(x));
  endfunction

  function automatic longint sat(input longint x);
    if (x > QMAX) return QMAX;
    if (x < QMIN) return QMIN;
    return x;
  endfunction

  task automatic pi(input longint r, input longint m, input longint kp, input longint ki,
                    input longint hi, inout longint integ, output longint u);
    longint e, p, c, s;
    e = sat(r - m);
    p = sat((kp * e) >>> 16);
    c = sat(integ + sat((ki * e) >>> 16));
    s = sat(p + c);
    if (s >= 0 && s <= hi) integ = c;
    u = (s > hi) ? hi : ((s < 0) ? 0 : s);
  endtask

  task automatic model_step();
    longint r, vh, dh, u;
    if (rst) begin
      m_iv = 0; m_ii = 0; m_iref = 0; m_duty = 0; m_cnt = 0; m_dv = 1'b0;
      return;
    end
    m_dv = smp_valid;
    if (!smp_valid) return;
    vh = (s32(iref_max) < 0) ? 0 : s32(iref_max);
    dh = (s32(duty_max) < 0) ? 0 : ((s32(duty_max) > 65535) ? 65535 : s32(duty_max));
    r = m_iref;
    if (m_cnt == 7) begin
      pi(s32(v_set), s32(v_meas), s32(kp_v), s32(ki_v), vh, m_iv, u);
      m_iref = u;
      r = u;
    end
    m_cnt = (m_cnt + 1) % 8;
    pi(r, s32(i_meas), s32(kp_i), s32(ki_i), dh, m_ii, u);
    m_duty = u;
  endtask

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s [%s] actual=%0d expected=%0d at %0t", req, tag, act, exp, $time);
    end
  endtask

  task automatic tick();
    model_step();
    @(negedge clk);
    chk("R1 ready", longint'(smp_ready), 1);
    chk("R1 duty_valid", longint'(duty_valid), longint'(m_dv));
    chk("R2 R4 iref", s32(iref), m_iref);
    chk("R3 R5 R6 R7 duty", s32(duty), m_duty);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  function automatic logic [31:0] near(input longint base, input int span);
    return 32'(base + longint'($urandom_range(0, 2 * span)) - longint'(span));
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog [%s] actual=timeout expected=finish", tag);
    finish_run();
  end

  initial begin
    // R8: reset state
    tag = "R8";
    smp_valid = 1'b1;
    for (int k = 0; k < 4; k++) tick();
    rst = 1'b0;
    smp_valid = 1'b0;

    // nominal gains, dense samples: R2 R3
    tag = "R3 dense";
    kp_i = 32'd7517;   ki_i = 32'd1660;
    kp_v = 32'd71188;  ki_v = 32'd2641;
    v_set = 32'd48 << 16;
    iref_max = 32'd30 << 16;
    duty_max = 32'd58982;
    for (int k = 0; k < 120; k++) begin
      smp_valid = 1'b1;
      v_meas = near(40 * 65536, 8 * 65536);
      i_meas = near(10 * 65536, 6 * 65536);
      tick();
    end

    // sparse samples with noisy idle inputs: R1 R9
    tag = "R9 sparse";
    for (int k = 0; k < 160; k++) begin
      smp_valid = ($urandom_range(0, 9) < 3);
      v_meas = $urandom();
      i_meas = $urandom();
      if (smp_valid) begin
        v_meas = near(46 * 65536, 4 * 65536);
        i_meas = near(15 * 65536, 10 * 65536);
      end
      tick();
    end

    // extreme gains and inputs: R6 R7
    tag = "R7 saturate";
    kp_i = 32'h7FFF_FFFF; ki_i = 32'h7FFF_0000;
    kp_v = 32'h7FFF_FFFF; ki_v = 32'h4000_0000;
    for (int k = 0; k < 64; k++) begin
      smp_valid = 1'b1;
      v_meas = (k % 16 < 8) ? 32'h8000_0000 : 32'h7FFF_FFFF;
      i_meas = (k % 5 == 0) ? 32'h7FFF_FFFF : 32'h8000_0001;
      tick();
    end

    // release after saturation: R6 recovery
    tag = "R6 recover";
    kp_i = 32'd7517;   ki_i = 32'd1660;
    kp_v = 32'd71188;  ki_v = 32'd2641;
    for (int k = 0; k < 64; k++) begin
      smp_valid = 1'b1;
      v_meas = near(49 * 65536, 2 * 65536);
      i_meas = near(12 * 65536, 3 * 65536);
      tick();
    end

    // limit handling: R4 R5
    tag = "R5 limits";
    kp_i = 32'd400000; kp_v = 32'd400000;
    for (int k = 0; k < 96; k++) begin
      smp_valid = 1'b1;
      duty_max = (k < 32) ? 32'h0002_0000 : ((k < 64) ? 32'hFFFF_0000 : 32'd30000);
      iref_max = (k < 48) ? 32'hFFFF_8000 : (32'd5 << 16);
      v_meas = near(20 * 65536, 20 * 65536);
      i_meas = near(0, 8 * 65536);
      tick();
    end

    // mid-run reset: R8
    tag = "R8 mid";
    rst = 1'b1;
    for (int k = 0; k < 2; k++) tick();
    rst = 1'b0;
    tag = "R2 after reset";
    for (int k = 0; k < 24; k++) begin
      smp_valid = (k % 3 != 1);
      v_meas = near(30 * 65536, 10 * 65536);
      i_meas = near(3 * 65536, 3 * 65536);
      tick();
    end

    finish_run();
  end
endmodule